// File: doc/BRIEF.md
# NAND Spare-Area ECC Packer

This block assembles the spare (out-of-band) bytes of a NAND page while the page is being programmed. Page data goes to the flash in 512-byte chunks. After each chunk the ECC engine presents its raw syndrome words. The block trims those words to their meaningful fields, packs them into bytes and places the bytes at fixed spare positions. Which positions are used depends on the ECC mode and the page size. The spare bytes leave the block as a byte stream with valid/ready flow control, and the flash-side logic forwards that stream to the device.

Three modes exist. In single-bit mode each chunk gives 3 inverted bytes. In four-bit standard mode each chunk gives 10 bytes, placed so that the factory bad-block marker is never overwritten. In four-bit interleaved mode a 16-byte spare group is streamed straight after every chunk. In the two non-interleaved modes the whole spare area is streamed once, after the last chunk.

The control is one state machine with these states: IDLE, WAIT (waiting for a chunk's ECC words), PACK (placing packed bytes into the spare image), GROUP (streaming a 16-byte interleaved group) and DUMP (streaming the whole spare image). These are its transitions:
- IDLE to WAIT on a start with a legal configuration. IDLE stays in IDLE on a start with an illegal one, and the error flag rises.
- WAIT to PACK when the ECC words are presented.
- PACK to GROUP in interleaved mode. PACK to WAIT when more chunks follow. PACK to DUMP after the last chunk.
- GROUP to WAIT at the end of a group when more chunks follow, and GROUP to IDLE at the end of the final group.
- DUMP to IDLE after the last spare byte.

Top module: `nand_spare_packer`

## Requirements
- R1: A start seen in IDLE latches `ecc_mode` (0 = single-bit, 1 = four-bit standard, 2 = four-bit interleaved) and `page_size` (0 = 512, 1 = 2048, 2 = 4096 bytes). If either field equals 3, `cfg_err` is high from the next cycle, no byte is ever offered, and the block stays idle. A later legal start clears `cfg_err`.
- R2: In single-bit mode, ECC word 0 (bits 31:0 of `ecc_words`) gives a 24-bit value: bits 11:0 form its low half and bits 27:16 its high half. That value is inverted and stored as 3 bytes, low byte first.
- R3: In single-bit mode, chunk c's 3 bytes occupy spare offsets B+3c to B+3c+2, where B is 0, 40 or 80 for page sizes 512, 2048 and 4096.
- R4: In four-bit modes, word j is bits 32j+31:32j of `ecc_words`, for j from 0 to 3. Each word yields two 10-bit fields, bits 9:0 then bits 25:16. The eight fields, ordered by word and then by field, are concatenated LSB-first into 80 bits and emitted as 10 bytes, lowest byte first.
- R5: In four-bit standard mode on a 512-byte page, the 10 bytes go to spare offsets 0–4, 6, 7 and 13–15 in that order. Offset 5 and offsets 8–12 stay 0xFF.
- R6: In four-bit standard mode, chunk c's bytes go to offsets 24+10c upward on 2048-byte pages and to 48+10c upward on 4096-byte pages.
- R7: In interleaved mode, a group of exactly 16 bytes is offered after every chunk: 6 bytes of 0xFF, then that chunk's 10 packed bytes.
- R8: In the non-interleaved modes, exactly 16, 64 or 128 spare bytes are streamed, only after the last of the 1, 4 or 8 chunks. Every offset not written with ECC reads 0xFF.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R10: `out_last` is high only with `out_valid`, and only on the final spare byte of the page (the last byte of the dump, or the last byte of the final group).
- R11: `ecc_valid` has no effect outside the wait-for-ECC state. A start has no effect while a page is in progress: `cfg_err` and the configuration in use are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a page; configuration sampled in IDLE |
| ecc_mode | input | 2 | 0 single-bit, 1 four-bit standard, 2 four-bit interleaved |
| page_size | input | 2 | 0 = 512, 1 = 2048, 2 = 4096 bytes |
| ecc_valid | input | 1 | ECC words for the current chunk are present |
| ecc_words | input | 128 | Four raw 32-bit ECC words, word 0 in the low bits |
| out_valid | output | 1 | A spare byte is offered |
| out_ready | input | 1 | Sink accepts the offered byte |
| out_data | output | 8 | Spare byte |
| out_last | output | 1 | Final spare byte of the page |
| cfg_err | output | 1 | Last start carried an illegal configuration |

## Verification
The bench uses the default parameters: four 32-bit ECC words and a 128-byte spare image. With these values every mode and page-size combination can be reached, including the 8-chunk, 128-byte cases that fill the image up to offset 127 and the single-bit case that stops at offset 103. A vector table covers all nine legal combinations, half of them with a stalling sink. Directed runs then cover both illegal encodings, stray ECC strobes while idle, and a start issued in the middle of a page.

// File: rtl/nsp_pkg.sv
package nsp_pkg;

    typedef enum logic [1:0] {
        ECC_1BIT    = 2'd0,
        ECC_4BIT    = 2'd1,
        ECC_4BIT_IL = 2'd2
    } ecc_mode_e;

    typedef enum logic [1:0] {
        PG_512 = 2'd0,
        PG_2K  = 2'd1,
        PG_4K  = 2'd2
    } page_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_PACK,
        S_GROUP,
        S_DUMP
    } state_e;

    function automatic logic [7:0] spare_len(input logic [1:0] psz);
        if (psz == PG_512)     return 8'd16;
        else if (psz == PG_2K) return 8'd64;
        else                   return 8'd128;
    endfunction

    function automatic logic [3:0] chunk_count(input logic [1:0] psz);
        if (psz == PG_512)     return 4'd1;
        else if (psz == PG_2K) return 4'd4;
        else                   return 4'd8;
    endfunction

endpackage

// File: rtl/nsp_ecc_packer.sv
module nsp_ecc_packer #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    parameter int FLD_W  = 10,
    parameter int SB_W   = 12,
    localparam int OUT_W = 2 * NWORDS * FLD_W
) (
    input  logic [NWORDS*WORD_W-1:0] raw,
    input  logic                     one_bit,
    output logic [OUT_W-1:0]         bytes_o
);
    localparam int HI_LSB = WORD_W / 2;

    logic [OUT_W-1:0]  stream;
    logic [2*SB_W-1:0] sb_val;

    // Two truncated fields per word, concatenated LSB-first
    for (genvar k = 0; k < 2 * NWORDS; k++) begin : g_fld
        assign stream[k*FLD_W +: FLD_W] =
            raw[(k/2)*WORD_W + (k%2)*HI_LSB +: FLD_W];
    end

    // Single-bit code: inverted so erased pages verify clean
    assign sb_val  = ~{raw[HI_LSB +: SB_W], raw[0 +: SB_W]};
    assign bytes_o = one_bit ? {{(OUT_W-2*SB_W){1'b1}}, sb_val} : stream;

endmodule

// File: rtl/nsp_pos_map.sv
module nsp_pos_map
    import nsp_pkg::*;
#(
    parameter int IDX = 0,
    parameter int AW  = 7
) (
    input  logic [1:0]    mode,
    input  logic [1:0]    psize,
    input  logic [2:0]    chunk,
    output logic [AW-1:0] pos
);
    always_comb begin
        int unsigned p;
        p = 0;
        if (mode == ECC_1BIT) begin
            if (psize == PG_2K)       p = 40;
            else if (psize == PG_4K)  p = 80;
            p = p + 3 * 32'(chunk) + IDX;
        end else begin
            if (psize == PG_512) begin
                // skip bad-block marker (5) and the free run 8..12
                if (IDX < 5)      p = IDX;
                else if (IDX < 7) p = IDX + 1;
                else              p = IDX + 6;
            end else if (psize == PG_2K) begin
                p = 24 + 10 * 32'(chunk) + IDX;
            end else begin
                p = 48 + 10 * 32'(chunk) + IDX;
            end
        end
        pos = AW'(p);
    end

endmodule

// File: rtl/nand_spare_packer.sv
module nand_spare_packer
    import nsp_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NWORDS    = 4,
    parameter int SPARE_MAX = 128,
    parameter int GROUP_LEN = 16,
    parameter int PREPAD    = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               ecc_mode,
    input  logic [1:0]               page_size,
    input  logic                     ecc_valid,
    input  logic [NWORDS*WORD_W-1:0] ecc_words,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [7:0]               out_data,
    output logic                     out_last,
    output logic                     cfg_err
);
    localparam int AW        = $clog2(SPARE_MAX);
    localparam int ECC_BYTES = (2 * NWORDS * 10) / 8;
    localparam int SB_BYTES  = 3;
    localparam int GW        = $clog2(GROUP_LEN);

    state_e st_q, st_nx;
    logic [1:0]               mode_q, psz_q;
    logic [2:0]               chunk_q;
    logic [AW-1:0]            cnt_q;
    logic [NWORDS*WORD_W-1:0] raw_q;
    logic                     err_q;
    logic [7:0]               spare_q [SPARE_MAX];

    logic [ECC_BYTES*8-1:0]   packed_w;
    logic [7:0]               pbyte [ECC_BYTES];
    logic [AW-1:0]            pos_w [ECC_BYTES];
    logic [AW:0]              len_w;
    logic [3:0]               nchunk_w;
    logic                     last_chunk, bad_cfg, hs, grp_end, dump_end, is_idle;
    logic [GW-1:0]            gidx;

    nsp_ecc_packer #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_pack (
        .raw     (raw_q),
        .one_bit (mode_q == ECC_1BIT),
        .bytes_o (packed_w)
    );

    for (genvar b = 0; b < ECC_BYTES; b++) begin : g_byte
        assign pbyte[b] = packed_w[8*b +: 8];
        nsp_pos_map #(.IDX(b), .AW(AW)) u_map (
            .mode  (mode_q),
            .psize (psz_q),
            .chunk (chunk_q),
            .pos   (pos_w[b])
        );
    end

    assign len_w      = (AW+1)'(spare_len(psz_q));
    assign nchunk_w   = chunk_count(psz_q);
    assign last_chunk = ({1'b0, chunk_q} == nchunk_w - 4'd1);
    assign bad_cfg    = (ecc_mode == 2'd3) || (page_size == 2'd3);
    assign hs         = out_valid && out_ready;
    assign grp_end    = (cnt_q == AW'(GROUP_LEN - 1));
    assign dump_end   = ({1'b0, cnt_q} == len_w - 1'b1);
    assign is_idle    = (st_q == S_IDLE);
    assign cfg_err    = err_q;
    assign gidx       = cnt_q[GW-1:0] - GW'(PREPAD);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_IDLE:  if (start && !bad_cfg) st_nx = S_WAIT;
            S_WAIT:  if (ecc_valid) st_nx = S_PACK;
            S_PACK:  begin
                if (mode_q == ECC_4BIT_IL) st_nx = S_GROUP;
                else if (last_chunk)       st_nx = S_DUMP;
                else                       st_nx = S_WAIT;
            end
            S_GROUP: if (hs && grp_end) st_nx = last_chunk ? S_IDLE : S_WAIT;
            S_DUMP:  if (hs && dump_end) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            mode_q  <= 2'd0;
            psz_q   <= 2'd0;
            chunk_q <= '0;
            cnt_q   <= '0;
            raw_q   <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: if (start) begin
                    err_q <= bad_cfg;
                    if (!bad_cfg) begin
                        mode_q  <= ecc_mode;
                        psz_q   <= page_size;
                        chunk_q <= '0;
                        cnt_q   <= '0;
                    end
                end
                S_WAIT: if (ecc_valid) raw_q <= ecc_words;
                S_PACK: begin
                    cnt_q <= '0;
                    if (mode_q != ECC_4BIT_IL && !last_chunk) chunk_q <= chunk_q + 3'd1;
                end
                S_GROUP: if (hs) begin
                    if (grp_end) begin
                        cnt_q   <= '0;
                        chunk_q <= chunk_q + 3'd1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_DUMP: if (hs) cnt_q <= cnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Spare image
    always_ff @(posedge clk) begin
        if (st_q == S_IDLE && start && !bad_cfg) begin
            for (int i = 0; i < SPARE_MAX; i++) spare_q[i] <= 8'hFF;
        end else if (st_q == S_PACK && mode_q != ECC_4BIT_IL) begin
            for (int i = 0; i < ECC_BYTES; i++)
                if (mode_q == ECC_4BIT || i < SB_BYTES) spare_q[pos_w[i]] <= pbyte[i];
        end
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'hFF;
        out_last  = 1'b0;
        unique case (st_q)
            S_GROUP: begin
                out_valid = 1'b1;
                if (cnt_q >= AW'(PREPAD) && 32'(gidx) < ECC_BYTES) out_data = pbyte[gidx];
                out_last = grp_end && last_chunk;
            end
            S_DUMP: begin
                out_valid = 1'b1;
                out_data  = spare_q[cnt_q];
                out_last  = dump_end;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nsp_checker.sv
module nsp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [1:0] ecc_mode,
    input logic [1:0] page_size,
    input logic       is_idle,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       cfg_err
);
    p_bad_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start && is_idle && (ecc_mode == 2'd3 || page_size == 2'd3) |=> cfg_err);

    p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    p_last_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start && !is_idle |=> $stable(cfg_err));

endmodule

bind nand_spare_packer nsp_checker u_nsp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ecc_mode  (ecc_mode),
    .page_size (page_size),
    .is_idle   (is_idle),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .cfg_err   (cfg_err)
);

// File: tb/test_nand_spare_packer.sv
module test_nand_spare_packer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   ecc_mode = 2'd0, page_size = 2'd0;
    logic         ecc_valid = 1'b0;
    logic [127:0] ecc_words = '0;
    logic         out_valid, out_ready = 1'b0, out_last, cfg_err;
    logic [7:0]   out_data;

    always #5 clk = ~clk;

    nand_spare_packer i_nand_spare_packer (
        .clk(clk), .rst_n(rst_n), .start(start), .ecc_mode(ecc_mode),
        .page_size(page_size), .ecc_valid(ecc_valid), .ecc_words(ecc_words),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .cfg_err(cfg_err)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_s [128];
    int exp_n;

    // {mode, page size, seed, backpressure}
    localparam logic [12:0] VEC [9] = '{
        {2'd0, 2'd0, 8'h11, 1'b0}, {2'd0, 2'd1, 8'h22, 1'b1}, {2'd0, 2'd2, 8'h33, 1'b0},
        {2'd1, 2'd0, 8'h44, 1'b1}, {2'd1, 2'd1, 8'h55, 1'b0}, {2'd1, 2'd2, 8'h66, 1'b1},
        {2'd2, 2'd0, 8'h77, 1'b0}, {2'd2, 2'd1, 8'h88, 1'b1}, {2'd2, 2'd2, 8'h99, 1'b0}
    };
    localparam int POS512 [10] = '{0, 1, 2, 3, 4, 6, 7, 13, 14, 15};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wgen(input int s, input int c, input int j);
        logic [31:0] a, b, d;
        a = 32'(s); b = 32'(c); d = 32'(j);
        return (a * 32'h9E3779B1) ^ (b * 32'h01000193) ^ (d * 32'h7F4A7C15) ^ 32'hC3A55A3C;
    endfunction

    function automatic string req_of(input int m, input int p);
        if (m == 0) return "R2,R3,R8";
        if (m == 1) return (p == 0) ? "R4,R5,R8" : "R4,R6,R8";
        return "R4,R7";
    endfunction

    task automatic build_exp(input int m, input int p, input int s);
        logic [7:0]  sp [128];
        logic [7:0]  eb [10];
        logic [79:0] st;
        logic [31:0] w [4];
        logic [23:0] v;
        int nch, len, base;
        nch  = (p == 0) ? 1 : (p == 1) ? 4 : 8;
        len  = (p == 0) ? 16 : (p == 1) ? 64 : 128;
        base = (p == 0) ? 0 : (p == 1) ? 40 : 80;
        for (int i = 0; i < 128; i++) sp[i] = 8'hFF;
        for (int c = 0; c < nch; c++) begin
            for (int j = 0; j < 4; j++) w[j] = wgen(s, c, j);
            if (m == 0) begin
                v = ~{w[0][27:16], w[0][11:0]};
                for (int i = 0; i < 3; i++) sp[base + 3*c + i] = v[8*i +: 8];
            end else begin
                st = '0;
                for (int k = 0; k < 8; k++)
                    st[10*k +: 10] = (k % 2 == 0) ? w[k/2][9:0] : w[k/2][25:16];
                for (int i = 0; i < 10; i++) eb[i] = st[8*i +: 8];
                if (m == 1) begin
                    for (int i = 0; i < 10; i++)
                        sp[(p == 0) ? POS512[i] : ((p == 1) ? 24 : 48) + 10*c + i] = eb[i];
                end else begin
                    for (int i = 0; i < 16; i++) exp_s[16*c + i] = (i < 6) ? 8'hFF : eb[i-6];
                end
            end
        end
        if (m == 2) exp_n = 16 * nch;
        else begin
            exp_n = len;
            for (int i = 0; i < len; i++) exp_s[i] = sp[i];
        end
    endtask

    task automatic drive_chunk(input int s, input int c);
        @(negedge clk);
        ecc_words = {wgen(s, c, 3), wgen(s, c, 2), wgen(s, c, 1), wgen(s, c, 0)};
        ecc_valid = 1'b1;
        @(negedge clk);
        ecc_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic collect(input int off, input int n, input bit bp, input string req);
        int idx = 0, cyc = 0;
        while (idx < n && cyc < 4000) begin
            @(negedge clk);
            out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
            if (out_valid && out_ready) begin
                check(out_data == exp_s[off+idx], req, int'(out_data), int'(exp_s[off+idx]));
                check(out_last == (off + idx == exp_n - 1), "R10", int'(out_last),
                      int'(off + idx == exp_n - 1));
                idx++;
            end
            cyc++;
        end
        check(idx == n, req, idx, n);
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid, req, int'(out_valid), 0);  // no surplus bytes
    endtask

    task automatic run_vec(input int m, input int p, input int s, input bit bp, input bit poke);
        int nch;
        nch = (p == 0) ? 1 : (p == 1) ? 4 : 8;
        @(negedge clk);
        start = 1'b1; ecc_mode = 2'(m); page_size = 2'(p);
        @(negedge clk);
        start = 1'b0;
        check(cfg_err == 1'b0, "R1", int'(cfg_err), 0);
        if (poke) begin  // R11: start mid-page is ignored
            start = 1'b1; ecc_mode = 2'd3; page_size = 2'((p + 1) % 3);
            @(negedge clk);
            start = 1'b0; ecc_mode = 2'(m); page_size = 2'(p);
            @(negedge clk);
            check(cfg_err == 1'b0, "R11", int'(cfg_err), 0);
        end
        build_exp(m, p, s);
        for (int c = 0; c < nch; c++) begin
            drive_chunk(s, c);
            if (m == 2) collect(16*c, 16, bp, poke ? "R11" : req_of(m, p));
        end
        if (m != 2) collect(0, exp_n, bp, poke ? "R11" : req_of(m, p));
    endtask

    task automatic bad_start(input int m, input int p);
        bit seen = 1'b0;
        @(negedge clk);
        start = 1'b1; ecc_mode = 2'(m); page_size = 2'(p);
        @(negedge clk);
        start = 1'b0;
        check(cfg_err == 1'b1, "R1", int'(cfg_err), 1);
        drive_chunk(5, 0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
        end
        check(!seen, "R1", int'(seen), 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && !out_last && !cfg_err, "R1", int'({out_valid, out_last, cfg_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !cfg_err, "R1", int'({out_valid, cfg_err}), 0);

        for (int v = 0; v < 9; v++)
            run_vec(int'(VEC[v][12:11]), int'(VEC[v][10:9]), int'(VEC[v][8:1]), VEC[v][0], 1'b0);

        bad_start(3, 0);
        bad_start(1, 3);
        run_vec(0, 1, 8'hA1, 1'b1, 1'b0);  // legal start clears the error flag (R1)

        drive_chunk(8'h5C, 0);             // R11: strobe while idle
        @(negedge clk);
        check(!out_valid, "R11", int'(out_valid), 0);
        run_vec(1, 0, 8'hB2, 1'b0, 1'b1);
        run_vec(2, 1, 8'hC3, 1'b1, 1'b1);

        finish_run();
    end

endmodule